// File: doc/BRIEF.md
# Register Bank With Independent Field Resets

This block is a bank of five 32-bit control registers that a CPU reads and writes through a simple request/response port. Each register splits into two 16-bit fields, a low half and a high half. No single reset governs every field. Each field instead has its own reset input, with its own polarity and its own sync or async timing. Each field also has its own reload value, which is either a fixed constant or a value taken from a live input pin.

The low halves each follow a separate reset input. The five high halves share one synchronous reset. Four of them reload a constant, and the fifth captures a 16-bit input at the reset edge. The CPU port has a reset of its own that only clears the response handshake. A request is accepted in any cycle where `req_valid` is high and the port is out of reset. Its response appears one cycle later.

Top module: `fieldreset_regfile`

## Requirements
- R1: Registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10. The low field is bits 15:0 and the high field is bits 31:16. A write loads both fields, and a write of zero clears the register. A read returns {high, low}. The response (`rsp_valid`=1, data, `rsp_err`=0) arrives in the cycle after the request.
- R2: Every low field reloads 0x1234. The low field at 0x00 reloads only on `rst`, which is synchronous and active high.
- R3: The low field at 0x04 reloads only on `lo1_rst`, which is synchronous and active high.
- R4: The low field at 0x08 reloads on `lo2_arst`, which is asynchronous and active high. A pulse shorter than a clock period that falls between edges still reloads it.
- R5: The low field at 0x0C reloads when `lo3_rst_n` is low at a clock edge (synchronous, active low).
- R6: The low field at 0x10 reloads as soon as `lo4_arst_n` goes low (asynchronous, active low), with no clock edge needed.
- R7: `hi_rst` (synchronous, active high) reloads all five high fields. The high fields at 0x00 to 0x0C reload 0x5678. Pulsing `rst` leaves every high field unchanged.
- R8: The high field at 0x10 reloads with the value on `hi4_init` at the clock edge where `hi_rst` is high.
- R9: A field reset changes only the fields tied to it. Every other field keeps its contents.
- R10: If a CPU write and a synchronous reset of a field land on the same edge, the reset wins for that field. The other half of the register still takes the written data.
- R11: When `bus_rst_n` is low at an edge, `rsp_valid` clears and no stored field changes.
- R12: An unmapped offset is any offset with bits 1:0 non-zero or with a word index of 5 or more. Reading one returns 0 with `rsp_err`=1. Writing one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main reset, synchronous, active high; low field at 0x00 |
| bus_rst_n | input | 1 | CPU port reset, synchronous, active low; clears handshake only |
| lo1_rst | input | 1 | Sync active-high reset of low field at 0x04 |
| lo2_arst | input | 1 | Async active-high reset of low field at 0x08 |
| lo3_rst_n | input | 1 | Sync active-low reset of low field at 0x0C |
| lo4_arst_n | input | 1 | Async active-low reset of low field at 0x10 |
| hi_rst | input | 1 | Sync active-high reset of all high fields |
| hi4_init | input | FIELD_W | Reload value for the high field at 0x10 |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 2*FIELD_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 2*FIELD_W | Read data |
| rsp_err | output | 1 | Unmapped-offset flag |

## Verification
The bench pulses each reset alone, after all registers are cleared to zero. A design with crossed reset wiring would then show 0x1234 or 0x5678 in the wrong register. The async resets get a 1 ns pulse placed mid-cycle; a design that samples them on the clock would miss the pulse and leave the field at zero. The bench also lands a write on the same edge as a field reset, where a design with the wrong priority returns the written half instead of the reload value. The `hi4_init` value is changed between resets, so a design that latched it once or used a constant is caught. Unmapped offsets, misaligned offsets and a pulse of the port reset round out the checks, which catch stray writes, wrong error flags and handshake resets that touch stored data.

// File: rtl/frr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the field-reset register bank.
// Assumes exactly five registers; the per-field reset wiring depends on it.
package frr_pkg;
    localparam int NREG = 5;
    // Low field reset style, bit i = register i
    localparam logic [NREG-1:0] LO_ASYNC   = 5'b10100;
    localparam logic [NREG-1:0] LO_ACT_LOW = 5'b11000;
    // High field whose reload value comes from an input pin
    localparam logic [NREG-1:0] HI_LIVE    = 5'b10000;
    localparam logic [15:0] LO_INIT = 16'h1234;
    localparam logic [15:0] HI_INIT = 16'h5678;
endpackage

// File: rtl/frr_field.sv
`timescale 1ns/1ps
// Module: one storage field with a selectable reset style.
// ASYNC picks an asynchronous reset, ACT_LOW picks an active-low reset.
// Reset always wins over a write on the same edge.
// Assumes rst_val is stable around the reset edge.
module frr_field #(
    parameter int W       = 16,
    parameter bit ASYNC   = 1'b0,
    parameter bit ACT_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_raw,
    input  logic [W-1:0] rst_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    generate
        if (ASYNC && !ACT_LOW) begin : g_async_hi
            // Async active-high reload, else write
            always_ff @(posedge clk or posedge rst_raw) begin
                if (rst_raw)    q <= rst_val;
                else if (wr_en) q <= wr_data;
            end
        end else if (ASYNC) begin : g_async_lo
            // Async active-low reload, else write
            always_ff @(posedge clk or negedge rst_raw) begin
                if (!rst_raw)   q <= rst_val;
                else if (wr_en) q <= wr_data;
            end
        end else begin : g_sync
            logic rst_act;
            // Normalise polarity of the sync reset
            always_comb rst_act = ACT_LOW ? !rst_raw : rst_raw;
            // Sync reload, else write
            always_ff @(posedge clk) begin
                if (rst_act)    q <= rst_val;
                else if (wr_en) q <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/frr_decode.sv
`timescale 1ns/1ps
// Module: byte-offset decoder to a one-hot register select.
// Offsets must be word aligned; anything else, or an index past NREG, misses.
module frr_decode #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel,
    output logic              hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    // Split offset into word index and alignment bits
    always_comb begin
        idx     = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
    end

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_sel
            // Select line for register i
            always_comb sel[i] = aligned && (idx == IDX_W'(i));
        end
    endgenerate

    // Any select means the offset is mapped
    always_comb hit = |sel;
endmodule

// File: rtl/frr_port.sv
`timescale 1ns/1ps
// Module: response stage of the CPU port.
// Registers the response one cycle after an accepted request.
// bus_rst_n is a sync active-low reset for this stage only.
module frr_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic              acc,
    input  logic              is_read,
    input  logic              hit,
    input  logic [DATA_W-1:0] rd_mux,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    // Response handshake and data registers
    always_ff @(posedge clk) begin
        if (!bus_rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc;
            if (acc) begin
                rsp_err   <= !hit;
                rsp_rdata <= (is_read && hit) ? rd_mux : '0;
            end
        end
    end
endmodule

// File: rtl/fieldreset_regfile.sv
`timescale 1ns/1ps
// Module: top of the register bank with independent field resets.
// Five registers, each a low and a high field with its own reset wiring.
// Assumes one request per cycle; requests during bus_rst_n low are dropped.
module fieldreset_regfile #(
    parameter int FIELD_W = 16,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_rst_n,
    input  logic                 lo1_rst,
    input  logic                 lo2_arst,
    input  logic                 lo3_rst_n,
    input  logic                 lo4_arst_n,
    input  logic                 hi_rst,
    input  logic [FIELD_W-1:0]   hi4_init,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2*FIELD_W-1:0] req_wdata,
    output logic                 rsp_valid,
    output logic [2*FIELD_W-1:0] rsp_rdata,
    output logic                 rsp_err
);
    import frr_pkg::*;
    localparam int DATA_W = 2 * FIELD_W;

    logic [NREG-1:0]              sel;
    logic                         hit;
    logic                         acc;
    logic [NREG-1:0]              lo_rst_raw;
    logic [NREG-1:0][FIELD_W-1:0] lo_q;
    logic [NREG-1:0][FIELD_W-1:0] hi_q;
    logic [DATA_W-1:0]            rd_mux;

    // Accept requests only while the port is out of reset
    always_comb acc = req_valid && bus_rst_n;

    // Gather low field reset pins, bit i = register i
    always_comb lo_rst_raw = {lo4_arst_n, lo3_rst_n, lo2_arst, lo1_rst, rst};

    frr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .addr (req_addr),
        .sel  (sel),
        .hit  (hit)
    );

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            logic             wr_i;
            logic [FIELD_W-1:0] hi_val;

            // Write strobe for register i
            always_comb wr_i = acc && req_write && sel[i];
            // High reload value: live pin or constant
            always_comb hi_val = HI_LIVE[i] ? hi4_init : FIELD_W'(HI_INIT);

            frr_field #(
                .W(FIELD_W), .ASYNC(LO_ASYNC[i]), .ACT_LOW(LO_ACT_LOW[i])
            ) u_lo (
                .clk     (clk),
                .rst_raw (lo_rst_raw[i]),
                .rst_val (FIELD_W'(LO_INIT)),
                .wr_en   (wr_i),
                .wr_data (req_wdata[FIELD_W-1:0]),
                .q       (lo_q[i])
            );

            frr_field #(.W(FIELD_W), .ASYNC(1'b0), .ACT_LOW(1'b0)) u_hi (
                .clk     (clk),
                .rst_raw (hi_rst),
                .rst_val (hi_val),
                .wr_en   (wr_i),
                .wr_data (req_wdata[DATA_W-1:FIELD_W]),
                .q       (hi_q[i])
            );
        end
    endgenerate

    // Read multiplexer over the selected register
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NREG; k++)
            if (sel[k]) rd_mux = {hi_q[k], lo_q[k]};
    end

    frr_port #(.DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .bus_rst_n (bus_rst_n),
        .acc       (acc),
        .is_read   (!req_write),
        .hit       (hit),
        .rd_mux    (rd_mux),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );
endmodule

// File: rtl/frr_checker.sv
`timescale 1ns/1ps
// Module: property checker for fieldreset_regfile, attached by bind.
module frr_checker #(
    parameter int FIELD_W = 16,
    parameter int NREG    = 5
) (
    input logic                         clk,
    input logic                         bus_rst_n,
    input logic                         rst,
    input logic                         lo2_arst,
    input logic                         lo4_arst_n,
    input logic                         hi_rst,
    input logic [FIELD_W-1:0]           hi4_init,
    input logic                         req_valid,
    input logic                         rsp_valid,
    input logic                         rsp_err,
    input logic [2*FIELD_W-1:0]         rsp_rdata,
    input logic [NREG-1:0][FIELD_W-1:0] lo_q,
    input logic [NREG-1:0][FIELD_W-1:0] hi_q
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        req_valid |=> rsp_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    lo0_reload_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        rst |=> lo_q[0] == 16'h1234);
    // R4
    lo2_async_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        lo2_arst |=> lo_q[2] == 16'h1234);
    // R6
    lo4_async_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !lo4_arst_n |=> lo_q[4] == 16'h1234);
    // R7
    hi_const_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        hi_rst |=> hi_q[0] == 16'h5678 && hi_q[3] == 16'h5678);
    // R8
    hi_live_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        hi_rst |=> hi_q[4] == $past(hi4_init));
    // R9
    hi_isolate_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !hi_rst && !req_valid |=> $stable(hi_q));
    // R12
    err_zero_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == '0);
endmodule

bind fieldreset_regfile frr_checker #(.FIELD_W(FIELD_W), .NREG(frr_pkg::NREG)) u_chk (
    .clk        (clk),
    .bus_rst_n  (bus_rst_n),
    .rst        (rst),
    .lo2_arst   (lo2_arst),
    .lo4_arst_n (lo4_arst_n),
    .hi_rst     (hi_rst),
    .hi4_init   (hi4_init),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .lo_q       (lo_q),
    .hi_q       (hi_q)
);

// File: tb/fieldreset_regfile_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios for fieldreset_regfile, one task each.
module fieldreset_regfile_test;
    logic        clk = 1'b0;
    logic        rst, bus_rst_n, lo1_rst, lo2_arst, lo3_rst_n, lo4_arst_n, hi_rst;
    logic [15:0] hi4_init;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fieldreset_regfile uut (
        .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .lo1_rst(lo1_rst),
        .lo2_arst(lo2_arst), .lo3_rst_n(lo3_rst_n), .lo4_arst_n(lo4_arst_n),
        .hi_rst(hi_rst), .hi4_init(hi4_init), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic [7:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cpu_read(logic [7:0] a, output logic [31:0] d, output logic e, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; e = rsp_err; v = rsp_valid;
    endtask

    task automatic read_chk(string req, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d; logic e; logic v;
        cpu_read(a, d, e, v);
        check({req, " valid"}, {31'd0, v}, 32'd1);
        check({req, " err"}, {31'd0, e}, 32'd0);
        check(req, d, exp);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 5; i++) cpu_write(8'(i * 4), 32'h0);
    endtask

    task automatic read_all(string req, logic [31:0] e0, logic [31:0] e1,
                            logic [31:0] e2, logic [31:0] e3, logic [31:0] e4);
        read_chk(req, 8'h00, e0);
        read_chk(req, 8'h04, e1);
        read_chk(req, 8'h08, e2);
        read_chk(req, 8'h0C, e3);
        read_chk(req, 8'h10, e4);
    endtask

    task automatic t_reset_state();
        check("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        read_all("R2 R7 R8 reset state", 32'h5678_1234, 32'h5678_1234,
                 32'h5678_1234, 32'h5678_1234, 32'hABCD_1234);
    endtask

    task automatic t_write_read();
        cpu_write(8'h00, 32'hDEAD_BEEF);
        cpu_write(8'h04, 32'h0123_4567);
        cpu_write(8'h08, 32'hFFFF_0000);
        cpu_write(8'h0C, 32'h0000_FFFF);
        cpu_write(8'h10, 32'hA5A5_5A5A);
        read_all("R1 write/read", 32'hDEAD_BEEF, 32'h0123_4567,
                 32'hFFFF_0000, 32'h0000_FFFF, 32'hA5A5_5A5A);
        clear_all();
        read_all("R1 write zero", 0, 0, 0, 0, 0);
    endtask

    task automatic t_main_rst();
        clear_all();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        read_all("R2 R7 R9 main rst", 32'h0000_1234, 0, 0, 0, 0);
    endtask

    task automatic t_lo1();
        clear_all();
        lo1_rst = 1'b1; @(negedge clk); lo1_rst = 1'b0;
        read_all("R3 R9 lo1_rst", 0, 32'h0000_1234, 0, 0, 0);
    endtask

    task automatic t_lo2_async();
        clear_all();
        #2 lo2_arst = 1'b1;
        #1 lo2_arst = 1'b0;
        @(negedge clk);
        read_all("R4 R9 lo2_arst short pulse", 0, 0, 32'h0000_1234, 0, 0);
    endtask

    task automatic t_lo3();
        clear_all();
        lo3_rst_n = 1'b0; @(negedge clk); lo3_rst_n = 1'b1;
        read_all("R5 R9 lo3_rst_n", 0, 0, 0, 32'h0000_1234, 0);
    endtask

    task automatic t_lo4_async();
        logic [31:0] d; logic e; logic v;
        clear_all();
        #2 lo4_arst_n = 1'b0;
        #1 lo4_arst_n = 1'b1;
        @(negedge clk);
        read_all("R6 R9 lo4_arst_n short pulse", 0, 0, 0, 0, 32'h0000_1234);
        cpu_read(8'h10, d, e, v);
    endtask

    task automatic t_hi_rst();
        clear_all();
        hi4_init = 16'h3210; hi_rst = 1'b1;
        @(negedge clk);
        hi_rst = 1'b0; hi4_init = 16'h9999;
        read_all("R7 R8 R9 hi_rst", 32'h5678_0000, 32'h5678_0000,
                 32'h5678_0000, 32'h5678_0000, 32'h3210_0000);
    endtask

    task automatic t_collide();
        clear_all();
        lo1_rst = 1'b1;
        cpu_write(8'h04, 32'hAAAA_BBBB);
        lo1_rst = 1'b0;
        read_chk("R10 write vs lo1_rst", 8'h04, 32'hAAAA_1234);
        hi_rst = 1'b1; hi4_init = 16'h0F0F;
        cpu_write(8'h08, 32'h1111_2222);
        hi_rst = 1'b0;
        read_chk("R10 write vs hi_rst", 8'h08, 32'h5678_2222);
    endtask

    task automatic t_bus_rst();
        cpu_write(8'h00, 32'hCAFE_F00D);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        bus_rst_n = 1'b0;
        @(negedge clk);
        check("R11 bus reset clears rsp_valid", {31'd0, rsp_valid}, 32'd0);
        bus_rst_n = 1'b1;
        read_chk("R11 fields kept", 8'h00, 32'hCAFE_F00D);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e; logic v;
        clear_all();
        cpu_read(8'h14, d, e, v);
        check("R12 unmapped read data", d, 32'h0);
        check("R12 unmapped read err", {31'd0, e}, 32'd1);
        cpu_read(8'h06, d, e, v);
        check("R12 misaligned read err", {31'd0, e}, 32'd1);
        cpu_write(8'h14, 32'h7777_7777);
        cpu_write(8'h01, 32'h6666_6666);
        cpu_write(8'hFC, 32'h5555_5555);
        read_all("R12 unmapped write ignored", 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; bus_rst_n = 1'b0; lo1_rst = 1'b1; lo2_arst = 1'b1;
        lo3_rst_n = 1'b0; lo4_arst_n = 1'b0; hi_rst = 1'b1; hi4_init = 16'hABCD;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0; bus_rst_n = 1'b1; lo1_rst = 1'b0; lo2_arst = 1'b0;
        lo3_rst_n = 1'b1; lo4_arst_n = 1'b1; hi_rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_write_read();
        t_main_rst();
        t_lo1();
        t_lo2_async();
        t_lo3();
        t_lo4_async();
        t_hi_rst();
        t_collide();
        t_bus_rst();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule